// File: doc/BRIEF.md
# Three-Wire Serial Configuration Register Port

This block receives write-only configuration frames over a three-wire serial link made of an active-low select, a serial clock and a data line. It writes those frames into a bank of five 8-bit configuration registers. A fast system clock oversamples all three serial lines. Each line passes through a two-stage synchronizer, and the serial clock's rising edges are found by edge detection.

A frame is exactly sixteen bits, sent MSB first. It carries a 2-bit chip address, a direction flag, a 5-bit register address and an 8-bit data byte. The write takes effect only when select returns high, and only if all of these hold:
- exactly sixteen clocks arrived while select was low;
- the chip address matches the strap inputs;
- the direction flag is 1.

A power-down input, active low, forces every register to its default and blocks writes. The decoded register fields drive the output ports directly.

The frame state machine has four states:
- **IDLE**: waits for select to go low.
- **SHIFT**: counts and shifts in bits.
- **OVERRUN**: entered on a seventeenth clock; the frame is then dropped when select rises.
- **COMMIT**: a one-cycle write strobe.

Transitions:
- IDLE→SHIFT when select is low.
- SHIFT→COMMIT when select rises on a valid frame.
- SHIFT→IDLE when select rises on an invalid frame.
- SHIFT→OVERRUN on a clock edge after sixteen bits.
- OVERRUN→IDLE when select rises.
- COMMIT→IDLE always.
- Any state→IDLE while powered down.

Top module: `ctl3w_regport`

## Requirements
- R1: Frame bits are taken on rising serial clock edges in the order chip[1], chip[0], direction, address[4:0], data[7:0], MSB first.
- R2: A frame whose direction bit (third bit) is 0 changes no register.
- R3: A frame whose chip field differs from `strap_addr` changes no register.
- R4: No register changes while select is still low; a valid frame commits only after select rises.
- R5: Writes to register addresses 5 through 31 change no register.
- R6: After reset the register images are: reg0 = 0x0B, reg1 = 0x01, reg2 = 0x94, reg3 = 0xFF, reg4 = 0xFF.
- R7: Bit 0 of reg0 and bit 0 of reg1 are one shared run flag; writing either register updates it.
- R8: A frame with fewer or more than 16 serial clock rises while select is low is discarded.
- R9: While `powered` is low all registers read their defaults and frames are not written; the defaults remain after `powered` returns high.
- R10: Field map. reg0: [4] `clk_src_ext`, [3:1] `fmt_sel`, [0] run; bits 7:5 read 0. reg1: [7:6] `rate_sel`, [5:4] `speed_sel`, [3:1] `ratio_sel`, [0] run. reg2: [7:4] `mix_mode`, [3:2] `emph_sel`, [1] `gain_link`, [0] `mute_req`. reg3 drives `gain_l` and reg4 drives `gain_r`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| powered | input | 1 | Low = power-down: registers held at defaults, writes blocked |
| strap_addr | input | 2 | Chip address straps the frame must match |
| sel_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock; data sampled on its rising edge |
| sdin | input | 1 | Serial data |
| clk_src_ext | output | 1 | reg0 bit 4 |
| fmt_sel | output | 3 | reg0 bits 3:1 |
| core_run | output | 1 | Shared run flag (bit 0 of reg0 and reg1) |
| rate_sel | output | 2 | reg1 bits 7:6 |
| speed_sel | output | 2 | reg1 bits 5:4 |
| ratio_sel | output | 3 | reg1 bits 3:1 |
| mix_mode | output | 4 | reg2 bits 7:4 |
| emph_sel | output | 2 | reg2 bits 3:2 |
| gain_link | output | 1 | reg2 bit 1 |
| mute_req | output | 1 | reg2 bit 0 |
| gain_l | output | 8 | reg3 |
| gain_r | output | 8 | reg4 |

## Verification
The bench targets the frame-length boundary by sending 15- and 17-clock frames. A counter that is off by one, or that does not saturate, would commit one of them or shift a wrong byte into a register. It also writes the run flag through each register in turn. A design that keeps two separate copies of that flag would show a run flag that tracks only one of the two registers. It checks the outputs while select is still low after sixteen clocks, to catch a design that commits early. It also drives a frame during power-down and then raises `powered`; a design that latched that frame would show non-default values afterwards.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;
    localparam int FRAME_BITS = 16;
    localparam int CHIP_W     = 2;
    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 8;
    localparam int NUM_REGS   = 5;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_OVERRUN,
        ST_COMMIT
    } fr_state_e;

    localparam logic [DATA_W-1:0] DEF_R0 = 8'h0B;
    localparam logic [DATA_W-1:0] DEF_R1 = 8'h01;
    localparam logic [DATA_W-1:0] DEF_R2 = 8'h94;
    localparam logic [DATA_W-1:0] DEF_R3 = 8'hFF;
    localparam logic [DATA_W-1:0] DEF_R4 = 8'hFF;
endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
    parameter int               WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic st1, st2;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st1 <= RST_VAL[g];
                st2 <= RST_VAL[g];
            end else begin
                st1 <= din[g];
                st2 <= st1;
            end
        end
        assign dout[g] = st2;
    end
endmodule

// File: rtl/ctl3w_frame_fsm.sv
module ctl3w_frame_fsm
    import ctl3w_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              powered,
    input  logic [CHIP_W-1:0] strap_addr,
    input  logic              sel_s,
    input  logic              sclk_s,
    input  logic              sdin_s,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_BITS);

    fr_state_e              state, nstate;
    logic                   sclk_q;
    logic [FRAME_BITS-1:0]  shreg;
    logic [CNT_W-1:0]       bit_cnt;
    logic                   sclk_rise;
    logic                   frame_ok;

    assign sclk_rise = sclk_s & ~sclk_q;
    assign frame_ok  = (bit_cnt == FULL_CNT)
                    && (shreg[FRAME_BITS-1 -: CHIP_W] == strap_addr)
                    && shreg[FRAME_BITS-1-CHIP_W];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        state <= ST_IDLE;
        else if (!powered) state <= ST_IDLE;
        else               state <= nstate;
    end

    // next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:    if (!sel_s) nstate = ST_SHIFT;
            ST_SHIFT: begin
                if (sel_s)
                    nstate = frame_ok ? ST_COMMIT : ST_IDLE;
                else if (sclk_rise && bit_cnt == FULL_CNT)
                    nstate = ST_OVERRUN;
            end
            ST_OVERRUN: if (sel_s) nstate = ST_IDLE;
            ST_COMMIT:  nstate = ST_IDLE;
        endcase
    end

    // shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q  <= 1'b1;
            shreg   <= '0;
            bit_cnt <= '0;
        end else begin
            sclk_q <= sclk_s;
            if (state == ST_IDLE) begin
                bit_cnt <= '0;
            end else if (state == ST_SHIFT && sclk_rise && bit_cnt != FULL_CNT) begin
                shreg   <= {shreg[FRAME_BITS-2:0], sdin_s};
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        wr_en_o   = (state == ST_COMMIT);
        wr_addr_o = shreg[DATA_W +: ADDR_W];
        wr_data_o = shreg[DATA_W-1:0];
    end

    // R8
    commit_full_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> bit_cnt == FULL_CNT);
    // R3
    commit_chip_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> shreg[FRAME_BITS-1 -: CHIP_W] == strap_addr);
    // R2
    commit_dir_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> shreg[FRAME_BITS-1-CHIP_W]);
    // R4
    commit_after_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> $past(sel_s));
    // R8
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= FULL_CNT);
endmodule

// File: rtl/ctl3w_regbank.sv
module ctl3w_regbank
    import ctl3w_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              powered,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [4:0]        r0_img,
    output logic [DATA_W-1:0] r1_img,
    output logic [DATA_W-1:0] r2_img,
    output logic [DATA_W-1:0] r3_img,
    output logic [DATA_W-1:0] r4_img
);
    logic [3:0]        r0_hi;
    logic [6:0]        r1_hi;
    logic              run_q;
    logic [DATA_W-1:0] r2_q, r3_q, r4_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n || !powered) begin
            r0_hi <= DEF_R0[4:1];
            r1_hi <= DEF_R1[7:1];
            run_q <= DEF_R0[0];
            r2_q  <= DEF_R2;
            r3_q  <= DEF_R3;
            r4_q  <= DEF_R4;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_W'(0): begin r0_hi <= wr_data[4:1]; run_q <= wr_data[0]; end
                ADDR_W'(1): begin r1_hi <= wr_data[7:1]; run_q <= wr_data[0]; end
                ADDR_W'(2): r2_q <= wr_data;
                ADDR_W'(3): r3_q <= wr_data;
                ADDR_W'(4): r4_q <= wr_data;
                default:    ;
            endcase
        end
    end

    assign r0_img = {r0_hi, run_q};
    assign r1_img = {r1_hi, run_q};
    assign r2_img = r2_q;
    assign r3_img = r3_q;
    assign r4_img = r4_q;

    // R9
    pd_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !powered |=> (r2_img == DEF_R2 && r3_img == DEF_R3 && r1_img == DEF_R1));
    // R5
    bad_addr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n || !powered)
        (wr_en && wr_addr >= ADDR_W'(NUM_REGS)) |=> ($stable(r0_img) && $stable(r1_img)
            && $stable(r2_img) && $stable(r3_img) && $stable(r4_img)));
    // R4
    hold_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n || !powered)
        !wr_en |=> ($stable(r2_img) && $stable(r3_img) && $stable(r4_img)));
    // R7
    run_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r0_img[0] == r1_img[0]);
endmodule

// File: rtl/ctl3w_regport.sv
module ctl3w_regport
    import ctl3w_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       powered,
    input  logic [1:0] strap_addr,
    input  logic       sel_n,
    input  logic       sclk,
    input  logic       sdin,
    output logic       clk_src_ext,
    output logic [2:0] fmt_sel,
    output logic       core_run,
    output logic [1:0] rate_sel,
    output logic [1:0] speed_sel,
    output logic [2:0] ratio_sel,
    output logic [3:0] mix_mode,
    output logic [1:0] emph_sel,
    output logic       gain_link,
    output logic       mute_req,
    output logic [7:0] gain_l,
    output logic [7:0] gain_r
);
    logic [2:0]        sync_q;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [4:0]        r0_img;
    logic [DATA_W-1:0] r1_img, r2_img, r3_img, r4_img;

    ctl3w_sync #(.WIDTH(3), .RST_VAL(3'b110)) u_sync (
        .clk (clk), .rst_n (rst_n),
        .din ({sel_n, sclk, sdin}),
        .dout(sync_q)
    );

    ctl3w_frame_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .powered   (powered),
        .strap_addr(strap_addr),
        .sel_s     (sync_q[2]),
        .sclk_s    (sync_q[1]),
        .sdin_s    (sync_q[0]),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data)
    );

    ctl3w_regbank u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .powered(powered),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .r0_img (r0_img),
        .r1_img (r1_img),
        .r2_img (r2_img),
        .r3_img (r3_img),
        .r4_img (r4_img)
    );

    assign clk_src_ext = r0_img[4];
    assign fmt_sel     = r0_img[3:1];
    assign core_run    = r0_img[0];
    assign rate_sel    = r1_img[7:6];
    assign speed_sel   = r1_img[5:4];
    assign ratio_sel   = r1_img[3:1];
    assign mix_mode    = r2_img[7:4];
    assign emph_sel    = r2_img[3:2];
    assign gain_link   = r2_img[1];
    assign mute_req    = r2_img[0];
    assign gain_l      = r3_img;
    assign gain_r      = r4_img;
endmodule

// File: tb/ctl3w_regport_tb.sv
module ctl3w_regport_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       powered = 1'b1;
    logic [1:0] strap_addr = 2'b10;
    logic       sel_n = 1'b1;
    logic       sclk = 1'b1;
    logic       sdin = 1'b0;
    logic       clk_src_ext, core_run, gain_link, mute_req;
    logic [2:0] fmt_sel, ratio_sel;
    logic [1:0] rate_sel, speed_sel, emph_sel;
    logic [3:0] mix_mode;
    logic [7:0] gain_l, gain_r;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [7:0] e0, e1, e2, e3, e4;

    always #10 clk = ~clk;

    ctl3w_regport dut_i (
        .clk(clk), .rst_n(rst_n), .powered(powered), .strap_addr(strap_addr),
        .sel_n(sel_n), .sclk(sclk), .sdin(sdin),
        .clk_src_ext(clk_src_ext), .fmt_sel(fmt_sel), .core_run(core_run),
        .rate_sel(rate_sel), .speed_sel(speed_sel), .ratio_sel(ratio_sel),
        .mix_mode(mix_mode), .emph_sel(emph_sel), .gain_link(gain_link),
        .mute_req(mute_req), .gain_l(gain_l), .gain_r(gain_r)
    );

    task automatic set_defaults();
        e0 = 8'h0B; e1 = 8'h01; e2 = 8'h94; e3 = 8'hFF; e4 = 8'hFF;
    endtask

    // R7: bit 0 shared between reg0 and reg1; R10: reg0 bits 7:5 read 0
    task automatic model_write(input logic [4:0] a, input logic [7:0] d);
        case (a)
            5'd0: begin e0 = {3'b000, d[4:0]}; e1[0] = d[0]; end
            5'd1: begin e1 = d; e0[0] = d[0]; end
            5'd2: e2 = d;
            5'd3: e3 = d;
            5'd4: e4 = d;
            default: ;
        endcase
    endtask

    task automatic check(input string req);
        logic [39:0] act, exp;
        act = {3'b000, clk_src_ext, fmt_sel, core_run,
               rate_sel, speed_sel, ratio_sel, core_run,
               mix_mode, emph_sel, gain_link, mute_req, gain_l, gain_r};
        exp = {e0, e1, e2, e3, e4};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // R1: chip[1:0], dir, addr[4:0], data[7:0], MSB first
    task automatic shift_bits(input logic [15:0] w, input int nbits);
        @(negedge clk);
        sel_n = 1'b0;
        wait_clks(5);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b0;
            sdin = (i < 16) ? w[15-i] : 1'b0;
            wait_clks(5);
            sclk = 1'b1;
            wait_clks(5);
        end
    endtask

    task automatic send(input logic [1:0] chip, input logic dir, input logic [4:0] a,
                        input logic [7:0] d, input int nbits);
        shift_bits({chip, dir, a, d}, nbits);
        sel_n = 1'b1;
        wait_clks(10);
    endtask

    task automatic t_reset();
        set_defaults();
        check("R6 reset defaults");
    endtask

    task automatic t_fields();
        send(2'b10, 1'b1, 5'd3, 8'h5A, 16); model_write(5'd3, 8'h5A);
        check("R1 gain_l write");
        send(2'b10, 1'b1, 5'd4, 8'hA5, 16); model_write(5'd4, 8'hA5);
        check("R1 gain_r write");
        send(2'b10, 1'b1, 5'd2, 8'h6B, 16); model_write(5'd2, 8'h6B);
        check("R10 reg2 fields");
        send(2'b10, 1'b1, 5'd0, 8'hF7, 16); model_write(5'd0, 8'hF7);
        check("R10 reg0 fields, upper bits zero");
        send(2'b10, 1'b1, 5'd1, 8'hD3, 16); model_write(5'd1, 8'hD3);
        check("R10 reg1 fields");
    endtask

    task automatic t_chip_mismatch();
        send(2'b01, 1'b1, 5'd3, 8'h11, 16);
        check("R3 chip mismatch ignored");
        strap_addr = 2'b01;
        send(2'b01, 1'b1, 5'd3, 8'h22, 16); model_write(5'd3, 8'h22);
        check("R3 new strap matches");
        strap_addr = 2'b10;
    endtask

    task automatic t_dir_zero();
        send(2'b10, 1'b0, 5'd4, 8'h33, 16);
        check("R2 direction 0 ignored");
    endtask

    task automatic t_bad_addr();
        send(2'b10, 1'b1, 5'd5, 8'h00, 16);
        check("R5 addr 5 ignored");
        send(2'b10, 1'b1, 5'd31, 8'h00, 16);
        check("R5 addr 31 ignored");
    endtask

    task automatic t_pending();
        shift_bits({2'b10, 1'b1, 5'd3, 8'h77}, 16);
        wait_clks(10);
        check("R4 no change while select low");
        sel_n = 1'b1;
        wait_clks(10);
        model_write(5'd3, 8'h77);
        check("R4 commit after select rises");
    endtask

    task automatic t_shared_run();
        send(2'b10, 1'b1, 5'd1, 8'h00, 16); model_write(5'd1, 8'h00);
        check("R7 run cleared via reg1");
        send(2'b10, 1'b1, 5'd0, 8'h01, 16); model_write(5'd0, 8'h01);
        check("R7 run set via reg0");
    endtask

    task automatic t_bad_count();
        send(2'b10, 1'b1, 5'd4, 8'h3C, 15);
        check("R8 15 clocks discarded");
        send(2'b10, 1'b1, 5'd4, 8'h3C, 17);
        check("R8 17 clocks discarded");
        send(2'b10, 1'b1, 5'd4, 8'h3C, 16); model_write(5'd4, 8'h3C);
        check("R8 16 clocks accepted");
    endtask

    task automatic t_powerdown();
        @(negedge clk);
        powered = 1'b0;
        wait_clks(3);
        set_defaults();
        check("R9 defaults in power-down");
        send(2'b10, 1'b1, 5'd3, 8'h12, 16);
        check("R9 write blocked in power-down");
        powered = 1'b1;
        wait_clks(5);
        check("R9 defaults after power-up");
        send(2'b10, 1'b1, 5'd3, 8'h34, 16); model_write(5'd3, 8'h34);
        check("R9 writes resume");
    endtask

    initial begin
        wait_clks(4);
        rst_n = 1'b1;
        wait_clks(4);
        t_reset();
        t_fields();
        t_chip_mismatch();
        t_dir_zero();
        t_bad_addr();
        t_pending();
        t_shared_run();
        t_bad_count();
        t_powerdown();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule